// File: doc/BRIEF.md
# Fused Multiply-Add NaN Propagation Selector

This block sits on the special-case path of a fused multiply-add unit that evaluates A*B+C on binary32 operands. It sorts each operand into one of three classes: signaling NaN, quiet NaN or ordinary value. It then decides which input NaN becomes the result and returns that operand in quiet form. In default-NaN mode it returns the canonical default NaN instead. It also reports an invalid-operation flag.

The order in which NaNs win is not fixed in logic. A 7-bit rule word sets it. The word holds three 2-bit operand slots, from most to least preferred, and one bit that gives signaling NaNs precedence over quiet ones. One unit can therefore reproduce the three-NaN ordering of any architecture. A polarity input selects whether a set top fraction bit marks a signaling NaN or a quiet one. With the default parameter the outputs are registered, so every result appears one clock after its input.

Top module: `fma_nan_sel`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction field is nonzero. It is signaling when fraction bit 22 equals `sig_pol`, and quiet otherwise. With `sig_pol`=0, a set bit 22 therefore means quiet. Infinities and ordinary numbers are never NaNs.
- R2: The operand indices are A=0, B=1 and C=2. Rule bits [1:0] name the most preferred operand, bits [3:2] the next and bits [5:4] the least preferred. Bit 6 requests signaling-NaN precedence. A rule is legal only when its three slots form a permutation of {0,1,2}.
- R3: When bit 6 is set and at least one operand is a signaling NaN, the selected operand is the first operand in slot order that is a signaling NaN.
- R4: In all other cases the selected operand is the first operand in slot order that is a NaN of either kind. This includes bit 6 set with only quiet NaNs present.
- R5: The result is the selected operand with its sign and lower payload kept and bit 22 forced to the quiet value (`~sig_pol`). If that would leave the fraction zero, the result is the default NaN.
- R6: With `dflt_mode`=1 and any NaN input, the result is the default NaN and `out_sel`=3, whatever the rule. The default NaN is 0x7FC00000 when `sig_pol`=0 and 0x7FBFFFFF when `sig_pol`=1.
- R7: With `dflt_mode`=0, an illegal rule and any NaN input, `out_rule_err`=1, `out_valid`=0, `out_sel`=3 and `out_nan`=0.
- R8: `out_invalid` is 1 exactly when an accepted input has at least one signaling NaN. This holds regardless of mode and rule.
- R9: When no operand is a NaN, or `in_valid`=0, the outputs are `out_valid`=0, `out_sel`=3, `out_nan`=0, `out_invalid`=0 and `out_rule_err`=0.
- R10: With `OUT_REG`=1, all outputs reflect the input presented one clock edge earlier. A synchronous active-high reset puts the outputs in the idle state of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 32 | Multiplicand A |
| opnd_b | input | 32 | Multiplier B |
| opnd_c | input | 32 | Addend C |
| rule_word | input | 7 | Three preference slots and the signaling-first bit |
| dflt_mode | input | 1 | Return the default NaN instead of an input NaN |
| sig_pol | input | 1 | Value of fraction bit 22 that marks a signaling NaN |
| out_valid | output | 1 | A NaN result is present |
| out_sel | output | 2 | Index of the chosen operand, 3 when none is chosen |
| out_nan | output | 32 | Quieted NaN result |
| out_invalid | output | 1 | Invalid operation (a signaling NaN was seen) |
| out_rule_err | output | 1 | NaN present, not in default mode, rule illegal |

## Verification
The hardest case to reach is a rule whose signaling bit is set while the signaling NaN sits in a low-preference slot and a quiet NaN fills a higher one. Only that arrangement tells R3 apart from R4. The stimulus sweeps all twelve legal rules under both polarities across all 27 class combinations of the three operands, which covers every such arrangement. A second hard case is the quieting of a legacy-polarity signaling NaN with an empty payload into the default NaN. Directed vectors build that operand explicitly.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 3;
    localparam int IDX_W  = 2;
    localparam int RULE_W = N_OPS * IDX_W + 1;
    localparam int QBIT   = FRAC_W - 1;

    localparam logic [IDX_W-1:0] SEL_NONE = '1;

    typedef logic [FP_W-1:0] fp_word_t;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2
    } op_cls_e;

    typedef struct packed {
        logic             snan_first;
        logic [IDX_W-1:0] rank2;
        logic [IDX_W-1:0] rank1;
        logic [IDX_W-1:0] rank0;
    } rule_t;

    typedef struct packed {
        logic             valid;
        logic             invalid;
        logic             rule_err;
        logic [IDX_W-1:0] sel;
        fp_word_t         nan;
    } nan_res_t;

    localparam nan_res_t RES_IDLE = '{valid: 1'b0, invalid: 1'b0, rule_err: 1'b0,
                                      sel: SEL_NONE, nan: '0};

    function automatic fp_word_t default_nan(input logic sig_pol);
        fp_word_t w;
        w = '0;
        w[FP_W-2 -: EXP_W] = '1;
        if (sig_pol)
            w[QBIT-1:0] = '1;
        else
            w[QBIT] = 1'b1;
        return w;
    endfunction

    function automatic fp_word_t quieten(input fp_word_t w, input logic sig_pol);
        fp_word_t q;
        q = w;
        q[QBIT] = ~sig_pol;
        if (q[FRAC_W-1:0] == '0)
            q = default_nan(sig_pol);
        return q;
    endfunction

endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify
    import fma_nan_pkg::*;
(
    input  fp_word_t word_i,
    input  logic     sig_pol_i,
    output op_cls_e  cls_o
);

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &word_i[FP_W-2 -: EXP_W];
        frac_nz  = |word_i[FRAC_W-1:0];
        if (!(exp_ones && frac_nz))
            cls_o = CLS_NUM;
        else if (word_i[QBIT] == sig_pol_i)
            cls_o = CLS_SNAN;
        else
            cls_o = CLS_QNAN;
    end

endmodule

// File: rtl/fma_nan_rule_dec.sv
module fma_nan_rule_dec
    import fma_nan_pkg::*;
(
    input  logic [RULE_W-1:0] rule_word_i,
    output rule_t             rule_o,
    output logic              legal_o
);

    logic [IDX_W-1:0] slots [N_OPS];
    logic [N_OPS-1:0] seen;

    assign rule_o   = rule_t'(rule_word_i);
    assign slots[0] = rule_o.rank0;
    assign slots[1] = rule_o.rank1;
    assign slots[2] = rule_o.rank2;

    always_comb begin
        seen = '0;
        for (int r = 0; r < N_OPS; r++) begin
            if (slots[r] < IDX_W'(N_OPS))
                seen[slots[r]] = 1'b1;
        end
        legal_o = &seen;
    end

endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
    import fma_nan_pkg::*;
(
    input  op_cls_e          cls_i [N_OPS],
    input  rule_t            rule_i,
    input  logic             snan_only_i,
    output logic             found_o,
    output logic [IDX_W-1:0] sel_o
);

    logic [IDX_W-1:0] order [N_OPS];

    assign order[0] = rule_i.rank0;
    assign order[1] = rule_i.rank1;
    assign order[2] = rule_i.rank2;

    // Walk from least to most preferred so the earliest slot overwrites.
    always_comb begin
        found_o = 1'b0;
        sel_o   = SEL_NONE;
        for (int r = N_OPS - 1; r >= 0; r--) begin
            if (order[r] < IDX_W'(N_OPS)) begin
                if (snan_only_i ? (cls_i[order[r]] == CLS_SNAN)
                                : (cls_i[order[r]] != CLS_NUM)) begin
                    found_o = 1'b1;
                    sel_o   = order[r];
                end
            end
        end
    end

endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
    import fma_nan_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] opnd_c,
    input  logic [6:0]  rule_word,
    input  logic        dflt_mode,
    input  logic        sig_pol,
    output logic        out_valid,
    output logic [1:0]  out_sel,
    output logic [31:0] out_nan,
    output logic        out_invalid,
    output logic        out_rule_err
);

    fp_word_t         ops [N_OPS];
    op_cls_e          cls [N_OPS];
    logic [N_OPS-1:0] is_nan;
    logic [N_OPS-1:0] is_snan;
    rule_t            rule;
    logic             rule_legal;
    logic             snan_mode;
    logic             found;
    logic [IDX_W-1:0] pick_sel;
    nan_res_t         res_c;
    nan_res_t         res_q;

    assign ops[0] = opnd_a;
    assign ops[1] = opnd_b;
    assign ops[2] = opnd_c;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fma_nan_classify u_cls (
            .word_i   (ops[g]),
            .sig_pol_i(sig_pol),
            .cls_o    (cls[g])
        );
        assign is_nan[g]  = (cls[g] != CLS_NUM);
        assign is_snan[g] = (cls[g] == CLS_SNAN);
    end

    fma_nan_rule_dec u_dec (
        .rule_word_i(rule_word),
        .rule_o     (rule),
        .legal_o    (rule_legal)
    );

    assign snan_mode = (|is_snan) && rule.snan_first;

    fma_nan_pick u_pick (
        .cls_i      (cls),
        .rule_i     (rule),
        .snan_only_i(snan_mode),
        .found_o    (found),
        .sel_o      (pick_sel)
    );

    always_comb begin
        res_c          = RES_IDLE;
        res_c.invalid  = in_valid && (|is_snan);
        res_c.rule_err = in_valid && (|is_nan) && !dflt_mode && !rule_legal;
        if (in_valid && (|is_nan) && !res_c.rule_err) begin
            res_c.valid = 1'b1;
            if (dflt_mode) begin
                res_c.nan = default_nan(sig_pol);
            end else if (found) begin
                res_c.sel = pick_sel;
                res_c.nan = quieten(ops[pick_sel], sig_pol);
            end
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                res_q <= RES_IDLE;
            else
                res_q <= res_c;
        end

        a_r10_flags_follow_input: assert property (@(posedge clk) disable iff (rst)
            (out_valid || out_invalid || out_rule_err) |-> $past(in_valid));
    end else begin : g_comb
        assign res_q = res_c;
    end

    assign out_valid    = res_q.valid;
    assign out_sel      = res_q.sel;
    assign out_nan      = res_q.nan;
    assign out_invalid  = res_q.invalid;
    assign out_rule_err = res_q.rule_err;

    a_r7_err_excludes_valid: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_rule_err}));

    a_r5_result_is_quiet_nan: assert property (@(posedge clk) disable iff (rst)
        res_c.valid |-> (&res_c.nan[FP_W-2 -: EXP_W]) && (|res_c.nan[FRAC_W-1:0])
                        && (res_c.nan[QBIT] != sig_pol));

    a_r4_pick_is_nan: assert property (@(posedge clk) disable iff (rst)
        (res_c.valid && !dflt_mode) |-> (res_c.sel != SEL_NONE) && (cls[res_c.sel] != CLS_NUM));

    a_r3_snan_preferred: assert property (@(posedge clk) disable iff (rst)
        (res_c.valid && !dflt_mode && snan_mode) |-> (cls[res_c.sel] == CLS_SNAN));

    a_r9_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_sel == SEL_NONE) && (out_nan == '0));

endmodule

// File: tb/test_fma_nan_sel.sv
module test_fma_nan_sel;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] opnd_a, opnd_b, opnd_c;
    logic [6:0]  rule_word;
    logic        dflt_mode, sig_pol;
    logic        out_valid, out_invalid, out_rule_err;
    logic [1:0]  out_sel;
    logic [31:0] out_nan;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_nan_sel i_fma_nan_sel (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .rule_word(rule_word), .dflt_mode(dflt_mode), .sig_pol(sig_pol),
        .out_valid(out_valid), .out_sel(out_sel), .out_nan(out_nan),
        .out_invalid(out_invalid), .out_rule_err(out_rule_err)
    );

    typedef struct packed {
        logic [31:0] a, b, c;
        logic [6:0]  rule;
        logic        dflt, pol;
        logic        ev;
        logic [1:0]  esel;
        logic [31:0] enan;
        logic        einv, eerr;
    } vec_t;

    localparam logic [31:0] QA = 32'h7FC0_0011, SA = 32'h7F80_0022;
    localparam logic [31:0] QB = 32'hFFC0_0033, SB = 32'hFF80_0044;
    localparam logic [31:0] QC = 32'h7FC0_0055, SC = 32'h7F80_0066;
    localparam logic [31:0] NUM = 32'h3F80_0000, INF = 32'h7F80_0000;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{QA, SB, QC, 7'h52, 1'b0, 1'b0, 1'b1, 2'd1, 32'hFFC0_0044, 1'b1, 1'b0},  // R3
        '{QA, SB, QC, 7'h12, 1'b0, 1'b0, 1'b1, 2'd2, 32'h7FC0_0055, 1'b1, 1'b0},  // R4
        '{NUM, NUM, NUM, 7'h52, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 1'b0},       // R9
        '{SA, NUM, SC, 7'h24, 1'b0, 1'b0, 1'b1, 2'd0, 32'h7FC0_0022, 1'b1, 1'b0}, // R4
        '{SA, NUM, SC, 7'h06, 1'b0, 1'b0, 1'b1, 2'd2, 32'h7FC0_0066, 1'b1, 1'b0}, // R4
        '{QA, QB, NUM, 7'h00, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 1'b1},         // R7
        '{QA, QB, NUM, 7'h00, 1'b1, 1'b0, 1'b1, 2'd3, 32'h7FC0_0000, 1'b0, 1'b0}, // R6
        '{INF, NUM, NUM, 7'h24, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 1'b0},       // R1
        '{32'h7FC0_0000, NUM, 32'h7F80_0001, 7'h64, 1'b0, 1'b1,
          1'b1, 2'd0, 32'h7FBF_FFFF, 1'b1, 1'b0},                                 // R5
        '{32'h7FC0_0000, NUM, 32'h7F80_0001, 7'h06, 1'b0, 1'b1,
          1'b1, 2'd2, 32'h7F80_0001, 1'b1, 1'b0},                                 // R1
        '{QA, NUM, NUM, 7'h52, 1'b1, 1'b1, 1'b1, 2'd3, 32'h7FBF_FFFF, 1'b1, 1'b0}, // R6
        '{QA, NUM, NUM, 7'h15, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 1'b1},        // R2
        '{QA, QB, QC, 7'h52, 1'b0, 1'b0, 1'b1, 2'd2, 32'h7FC0_0055, 1'b0, 1'b0},  // R4
        '{QA, NUM, NUM, 7'h1B, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 1'b1}         // R2
    };
    localparam string VTAG [NV] = '{"R3", "R4", "R9", "R4", "R4", "R7", "R6",
                                    "R1", "R5", "R1", "R6", "R2", "R4", "R2"};

    // Slot orders: A=0 B=1 C=2, packed as {rank2, rank1, rank0}.
    localparam logic [5:0] PERMS [6] = '{
        {2'd2, 2'd1, 2'd0}, {2'd1, 2'd2, 2'd0}, {2'd2, 2'd0, 2'd1},
        {2'd0, 2'd2, 2'd1}, {2'd1, 2'd0, 2'd2}, {2'd0, 2'd1, 2'd2}
    };

    task automatic drive(input logic v, input logic [31:0] a, b, c,
                         input logic [6:0] r, input logic d, p);
        @(negedge clk);
        in_valid = v; opnd_a = a; opnd_b = b; opnd_c = c;
        rule_word = r; dflt_mode = d; sig_pol = p;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ev, input logic [1:0] es,
                         input logic [31:0] en, input logic ei, input logic ee);
        n_checks++;
        if ({out_valid, out_sel, out_nan, out_invalid, out_rule_err} !== {ev, es, en, ei, ee}) begin
            n_bad++;
            $display("FAIL %s actual v=%0b sel=%0d nan=%h inv=%0b err=%0b expected v=%0b sel=%0d nan=%h inv=%0b err=%0b",
                     tag, out_valid, out_sel, out_nan, out_invalid, out_rule_err, ev, es, en, ei, ee);
        end
    endtask

    function automatic logic [31:0] make_op(input int p, input int k, input logic pol);
        if (k == 0) return 32'h4000_0000 | 32'(p);
        return {p[0], 8'hFF, (k == 2) ? pol : ~pol, 22'(k * 256 + p + 1)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; opnd_a = '0; opnd_b = '0; opnd_c = '0;
        rule_word = '0; dflt_mode = 1'b0; sig_pol = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, 2'd3, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].rule, VECS[i].dflt, VECS[i].pol);
            check(VTAG[i], VECS[i].ev, VECS[i].esel, VECS[i].enan, VECS[i].einv, VECS[i].eerr);
        end

        // R9: NaNs without in_valid leave every output idle
        drive(1'b0, SA, SB, SC, 7'h52, 1'b0, 1'b0);
        check("R9 no valid", 1'b0, 2'd3, 32'h0, 1'b0, 1'b0);

        // R3/R4 sweep: 12 rules x 27 class patterns x both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int ri = 0; ri < 12; ri++) begin
                for (int pat = 0; pat < 27; pat++) begin
                    int k [3];
                    logic [31:0] w [3];
                    logic [6:0] rw;
                    logic any_s, any_n, ev;
                    logic [1:0] es;
                    logic [31:0] en;
                    k[0] = pat % 3; k[1] = (pat / 3) % 3; k[2] = pat / 9;
                    any_s = 1'b0; any_n = 1'b0;
                    for (int p = 0; p < 3; p++) begin
                        w[p] = make_op(p, k[p], 1'(pol));
                        any_s |= (k[p] == 2);
                        any_n |= (k[p] != 0);
                    end
                    rw = {1'(ri / 6), PERMS[ri % 6]};
                    ev = any_n; es = 2'd3; en = 32'h0;
                    if (any_n) begin
                        for (int s = 2; s >= 0; s--) begin
                            int idx;
                            idx = int'(PERMS[ri % 6][2*s +: 2]);
                            if ((any_s && rw[6]) ? (k[idx] == 2) : (k[idx] != 0)) begin
                                es = 2'(idx);
                                en = w[idx];
                            end
                        end
                        en[22] = ~1'(pol);
                    end
                    drive(1'b1, w[0], w[1], w[2], rw, 1'b0, 1'(pol));
                    check(rw[6] ? "R3 sweep" : "R4 sweep", ev, es, en, any_s, 1'b0);
                end
            end
        end

        // R10: reset with a NaN still applied returns to idle
        @(negedge clk);
        in_valid = 1'b1; opnd_a = SA; opnd_b = NUM; opnd_c = NUM;
        rule_word = 7'h24; dflt_mode = 1'b0; sig_pol = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset mid-run", 1'b0, 2'd3, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after reset", 1'b1, 2'd0, 32'h7FC0_0022, 1'b1, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule